// File: doc/BRIEF.md
# Multi-Group Message Mailbox

This block carries 32-bit messages from one processor to another through a set of small hardware queues. The queues sit behind a plain register bus with write, read, address, write-data and read-data signals. The queues are arranged in sender groups. Each group owns four channels, and each channel holds up to eight messages. A sender stores a word in a channel by writing that channel's data port. The receiver takes the oldest word by reading the same port. Read data is combinational from the address, and the pop happens at the clock edge that ends a read strobe.

Each channel has two interrupt sources:
- **Read source:** tells the receiver that words are waiting.
- **Write source:** tells the sender that enough free slots exist. The number of slots needed is set by a two-bit threshold code.

Each group drives one interrupt line. The line is the OR, over the group's channels, of every pending bit ANDed with its enable.

Each channel queue is a three-state machine:
- **States:** `CH_EMPTY`, `CH_PARTIAL` and `CH_FULL`.
- **fill:** `CH_EMPTY` to `CH_PARTIAL`, on an accepted push.
- **top-off:** `CH_PARTIAL` to `CH_FULL`, on a push alone when seven words are held.
- **drain:** `CH_PARTIAL` to `CH_EMPTY`, on a pop alone when one word is held.
- **release:** `CH_FULL` to `CH_PARTIAL`, on a pop alone.

A push together with a pop leaves the state where it is. The full and empty flags are decoded from the state.

Top module: `mbx_top`

## Requirements
- R1: Group g occupies addresses 0x100*g upward, and channel c's registers add 4*c. Within a group, the offsets are:
  - 0x20: read enables
  - 0x24: read pending
  - 0x30: write enables
  - 0x34: write pending
  - 0x50+4c: status
  - 0x60+4c: count
  - 0x70+4c: data
  - 0x80+4c: threshold (readable, bits [1:0])
  
  An access to one channel leaves every other channel's count unchanged.
- R2: Words written to a channel's data port come back from reads of that port in the order they were written, up to eight stored words.
- R3: The count register returns the number of stored words in bits [3:0]. Status bit 0 is the full flag and status bit 1 is the empty flag.
- R4: A write to a full channel is dropped and sets status bit 2, the overflow flag. Writing 1 to status bit 2 clears the overflow flag.
- R5: A read of an empty channel's data port returns zero and leaves the count at zero.
- R6: Read-pending bit 2c at offset 0x24 is set whenever channel c holds a word. It stays set after the channel drains. A write of 1 to it clears it only while the channel is empty.
- R7: Write-pending bit 2c+1 at offset 0x34 is set while the number of free slots is at least the threshold level. Threshold codes 0, 1, 2 and 3 give levels 1, 2, 4 and 8. A write of 1 to the bit clears it only while that condition is false.
- R8: Offset 0x20 stores only the even enable bits and offset 0x30 stores only the odd enable bits. Each reads back only its own bits. irq[g] is the OR of (enable AND pending) over group g.
- R9: A push and a pop to the same channel in one cycle behave as follows:
  - On a full channel, the pop returns the oldest word, the push is accepted, the count stays eight and no overflow is flagged.
  - On an empty channel, the pop returns zero and the push is stored.
- R10: After reset:
  - Counts, enables, threshold codes, overflow flags and read-pending bits are zero.
  - Every channel reports empty.
  - Every write-pending bit is set from the first clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; pops a data port at the clock edge |
| bus_addr | input | ADDR_W | Byte address; bits above 7 select the group |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | NUM_GROUPS | One interrupt line per group |

## Verification
The case where two functions meet in one cycle is a push and a pop to the same channel. The bench raises both strobes on one data address. It does this once with the channel holding eight words and once with it empty. It judges the result by three things:
- the word sampled on the read port before the edge;
- the count and status afterward, including the overflow flag;
- the order of every word drained afterward.

A second meeting point is a pending clear arriving while its set condition still holds. A swept threshold exercises this, and the bench checks that the set condition always wins.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        CH_EMPTY   = 2'd0,
        CH_PARTIAL = 2'd1,
        CH_FULL    = 2'd2
    } ch_state_e;

    // Group-level register offsets (low address byte)
    localparam logic [7:0] OFF_RD_EN   = 8'h20;
    localparam logic [7:0] OFF_RD_PEND = 8'h24;
    localparam logic [7:0] OFF_WR_EN   = 8'h30;
    localparam logic [7:0] OFF_WR_PEND = 8'h34;

    // Per-channel register rows (upper nibble of the low address byte)
    localparam logic [3:0] ROW_STAT  = 4'h5;
    localparam logic [3:0] ROW_COUNT = 4'h6;
    localparam logic [3:0] ROW_DATA  = 4'h7;
    localparam logic [3:0] ROW_THR   = 4'h8;

endpackage

// File: rtl/mbx_chan.sv
module mbx_chan
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] push_data,
    input  logic          ovf_clr,
    input  logic          thr_we,
    input  logic [1:0]    thr_wdata,
    input  logic          rdp_clr,
    input  logic          wrp_clr,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovf,
    output logic [1:0]    thr_code,
    output logic          rd_pend,
    output logic          wr_pend
);

    ch_state_e     state_q, state_d;
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          ovf_q, rdp_q, wrp_q;
    logic [1:0]    thr_q;
    logic [CW-1:0] room;
    logic          room_hit;
    logic          push_ok, pop_ok;

    // A pop needs a stored word; a push needs a free slot or a same-cycle pop.
    assign pop_ok  = pop && (state_q != CH_EMPTY);
    assign push_ok = push && ((state_q != CH_FULL) || pop_ok);

    // Next-state: fill, top-off, drain, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_EMPTY: begin
                if (push_ok) state_d = CH_PARTIAL;
            end
            CH_PARTIAL: begin
                if (push_ok && !pop_ok && cnt_q == CW'(DEPTH - 1))
                    state_d = CH_FULL;
                else if (pop_ok && !push_ok && cnt_q == CW'(1))
                    state_d = CH_EMPTY;
            end
            CH_FULL: begin
                if (pop_ok && !push_ok) state_d = CH_PARTIAL;
            end
            default: state_d = CH_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_EMPTY;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state and the count
    always_comb begin
        full     = (state_q == CH_FULL);
        empty    = (state_q == CH_EMPTY);
        head     = empty ? '0 : mem_q[rptr_q];
        room     = CW'(DEPTH) - cnt_q;
        room_hit = ({{(32-CW){1'b0}}, room} >= (32'd1 << thr_q));
    end

    // Pointers, count, flags and pending bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            thr_q  <= '0;
            rdp_q  <= 1'b0;
            wrp_q  <= 1'b0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + PW'(1);
            if (pop_ok)  rptr_q <= rptr_q + PW'(1);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
            if (push && !push_ok) ovf_q <= 1'b1;
            else if (ovf_clr)     ovf_q <= 1'b0;
            if (thr_we) thr_q <= thr_wdata;
            // Set conditions take priority over write-one-to-clear.
            rdp_q <= !empty   || (rdp_q && !rdp_clr);
            wrp_q <= room_hit || (wrp_q && !wrp_clr);
        end
    end

    // Message storage
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wptr_q] <= push_data;
    end

    assign count    = cnt_q;
    assign ovf      = ovf_q;
    assign thr_code = thr_q;
    assign rd_pend  = rdp_q;
    assign wr_pend  = wrp_q;

endmodule

// File: rtl/mbx_group.sv
module mbx_group
    import mbx_pkg::*;
#(
    parameter int CHANS = 4,
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int EW   = 2 * CHANS,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic          rd,
    input  logic [7:0]    off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);

    localparam logic [EW-1:0] RD_MASK = {CHANS{2'b01}};
    localparam logic [EW-1:0] WR_MASK = {CHANS{2'b10}};

    logic [3:0]       row;
    logic [1:0]       chi;
    logic             aligned;
    logic [EW-1:0]    en_q, pend;
    logic [DW-1:0]    head_a [CHANS];
    logic [CW-1:0]    cnt_a  [CHANS];
    logic [1:0]       thr_a  [CHANS];
    logic [CHANS-1:0] full_v, empty_v, ovf_v, rdp_v, wrp_v;

    assign row     = off[7:4];
    assign chi     = off[3:2];
    assign aligned = (off[1:0] == 2'b00);

    for (genvar c = 0; c < CHANS; c++) begin : g_ch
        logic hit;
        assign hit = sel && aligned && (chi == 2'(c));

        mbx_chan #(.DEPTH(DEPTH), .DW(DW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (wr && hit && row == ROW_DATA),
            .pop       (rd && hit && row == ROW_DATA),
            .push_data (wdata),
            .ovf_clr   (wr && hit && row == ROW_STAT && wdata[2]),
            .thr_we    (wr && hit && row == ROW_THR),
            .thr_wdata (wdata[1:0]),
            .rdp_clr   (wr && sel && off == OFF_RD_PEND && wdata[2*c]),
            .wrp_clr   (wr && sel && off == OFF_WR_PEND && wdata[2*c+1]),
            .head      (head_a[c]),
            .count     (cnt_a[c]),
            .full      (full_v[c]),
            .empty     (empty_v[c]),
            .ovf       (ovf_v[c]),
            .thr_code  (thr_a[c]),
            .rd_pend   (rdp_v[c]),
            .wr_pend   (wrp_v[c])
        );

        assign pend[2*c]   = rdp_v[c];
        assign pend[2*c+1] = wrp_v[c];
    end

    // Enables: each register owns only its half of the bit vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (sel && wr && off == OFF_RD_EN) begin
            en_q <= (en_q & WR_MASK) | (wdata[EW-1:0] & RD_MASK);
        end else if (sel && wr && off == OFF_WR_EN) begin
            en_q <= (en_q & RD_MASK) | (wdata[EW-1:0] & WR_MASK);
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (off == OFF_RD_EN)        rdata[EW-1:0] = en_q & RD_MASK;
        else if (off == OFF_RD_PEND) rdata[EW-1:0] = pend & RD_MASK;
        else if (off == OFF_WR_EN)   rdata[EW-1:0] = en_q & WR_MASK;
        else if (off == OFF_WR_PEND) rdata[EW-1:0] = pend & WR_MASK;
        else if (aligned) begin
            unique case (row)
                ROW_STAT:  rdata[2:0]    = {ovf_v[chi], empty_v[chi], full_v[chi]};
                ROW_COUNT: rdata[CW-1:0] = cnt_a[chi];
                ROW_DATA:  rdata         = head_a[chi];
                ROW_THR:   rdata[1:0]    = thr_a[chi];
                default:   rdata         = '0;
            endcase
        end
    end

    assign irq = |(en_q & pend);

endmodule

// File: rtl/mbx_top.sv
module mbx_top #(
    parameter int NUM_GROUPS = 2,
    parameter int CHANS      = 4,
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [NUM_GROUPS-1:0] irq
);

    localparam int GW = ADDR_W - 8;

    logic [31:0]           grp_rdata [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] grp_sel;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_sel[g] = (bus_addr[ADDR_W-1:8] == GW'(g));

        mbx_group #(.CHANS(CHANS), .DEPTH(DEPTH), .DW(32)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (grp_sel[g]),
            .wr    (bus_wr),
            .rd    (bus_rd),
            .off   (bus_addr[7:0]),
            .wdata (bus_wdata),
            .rdata (grp_rdata[g]),
            .irq   (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_sel[g]) bus_rdata = grp_rdata[g];
        end
    end

endmodule

// File: rtl/mbx_chan_chk.sv
module mbx_chan_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push,
    input logic          pop,
    input logic          ovf_clr,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          empty,
    input logic          ovf,
    input logic [1:0]    thr_code,
    input logic          rd_pend,
    input logic          wr_pend
);

    assert_flags_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, empty}) && (full == (count == CW'(DEPTH))) && (empty == (count == '0)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> ($stable(count) && ovf));

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (count == '0));

    assert_rdpend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |=> rd_pend);

    assert_wrpend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(DEPTH) - 32'(count)) >= (32'd1 << thr_code)) |=> wr_pend);

    assert_push_pop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full && !ovf_clr) |=> (full && $stable(ovf)));

endmodule

bind mbx_chan mbx_chan_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .ovf_clr  (ovf_clr),
    .count    (count),
    .full     (full),
    .empty    (empty),
    .ovf      (ovf),
    .thr_code (thr_code),
    .rd_pend  (rd_pend),
    .wr_pend  (wr_pend)
);

// File: tb/tb_mbx_top.sv
`timescale 1ns/1ps
module tb_mbx_top;

    localparam int NG = 2;
    localparam int NC = 4;
    localparam int DEPTH = 8;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NG-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbx_top #(.NUM_GROUPS(NG), .CHANS(NC), .DEPTH(DEPTH), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [AW-1:0] ad(input int g, input int off);
        return AW'(g * 256 + off);
    endfunction

    function automatic logic [31:0] pat(input int g, input int c, input int k);
        return {8'hA5, 8'(g), 8'(c), 8'(k)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_t(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_t(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic both_t(input logic [AW-1:0] a, input logic [31:0] wd, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_wr = 1'b1; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: reset state
        chk("R10 irq", 32'(irq), 32'd0);
        for (int g = 0; g < NG; g++) begin
            rd_t(ad(g, 'h20), v); chk("R10 rd enables", v, 32'd0);
            rd_t(ad(g, 'h30), v); chk("R10 wr enables", v, 32'd0);
            rd_t(ad(g, 'h24), v); chk("R10 rd pending", v, 32'd0);
            rd_t(ad(g, 'h34), v); chk("R10 wr pending", v, 32'hAA);
            for (int c = 0; c < NC; c++) begin
                rd_t(ad(g, 'h50 + 4*c), v); chk("R10 status", v, 32'd2);
                rd_t(ad(g, 'h60 + 4*c), v); chk("R10 count", v, 32'd0);
                rd_t(ad(g, 'h80 + 4*c), v); chk("R10 threshold", v, 32'd0);
            end
        end

        // Sweep every channel: fill level x threshold code
        for (int g = 0; g < NG; g++) begin
            for (int c = 0; c < NC; c++) begin
                for (int k = 0; k <= DEPTH; k++) begin
                    if (k > 0) wr_t(ad(g, 'h70 + 4*c), pat(g, c, k-1));
                    rd_t(ad(g, 'h60 + 4*c), v); chk("R3 count", v, 32'(k));
                    rd_t(ad(g, 'h50 + 4*c), v);
                    chk("R3 status flags", v, {30'd0, k == 0, k == DEPTH});
                    for (int code = 0; code < 4; code++) begin
                        wr_t(ad(g, 'h80 + 4*c), 32'(code));
                        wr_t(ad(g, 'h34), 32'd1 << (2*c + 1));
                        rd_t(ad(g, 'h34), v);
                        chk("R7 write pending vs threshold", (v >> (2*c + 1)) & 32'd1,
                            32'((DEPTH - k) >= (1 << code)));
                    end
                    if (k == DEPTH) begin
                        for (int g2 = 0; g2 < NG; g2++) begin
                            for (int c2 = 0; c2 < NC; c2++) begin
                                if (g2 != g || c2 != c) begin
                                    rd_t(ad(g2, 'h60 + 4*c2), v);
                                    chk("R1 neighbour count", v, 32'd0);
                                end
                            end
                        end
                    end
                end
                // R4: overflow
                wr_t(ad(g, 'h70 + 4*c), pat(g, c, 99));
                rd_t(ad(g, 'h50 + 4*c), v); chk("R4 overflow flag", v, 32'd5);
                rd_t(ad(g, 'h60 + 4*c), v); chk("R4 count after drop", v, 32'd8);
                wr_t(ad(g, 'h50 + 4*c), 32'd4);
                rd_t(ad(g, 'h50 + 4*c), v); chk("R4 overflow cleared", v, 32'd1);
                rd_t(ad(g, 'h80 + 4*c), v); chk("R1 threshold readback", v, 32'd3);
                // R2: order
                for (int k = 0; k < DEPTH; k++) begin
                    rd_t(ad(g, 'h70 + 4*c), v); chk("R2 fifo order", v, pat(g, c, k));
                end
                // R5: empty read
                rd_t(ad(g, 'h70 + 4*c), v); chk("R5 empty read value", v, 32'd0);
                rd_t(ad(g, 'h60 + 4*c), v); chk("R5 empty count", v, 32'd0);
                wr_t(ad(g, 'h80 + 4*c), 32'd0);
                wr_t(ad(g, 'h24), 32'd1 << (2*c));
                rd_t(ad(g, 'h24), v); chk("R6 cleared after drain", v, 32'd0);
            end
        end

        // R6: sticky read pending
        wr_t(ad(1, 'h78), 32'h1111_0001);
        wr_t(ad(1, 'h78), 32'h1111_0002);
        rd_t(ad(1, 'h24), v); chk("R6 set while data", v, 32'h10);
        wr_t(ad(1, 'h24), 32'h10);
        rd_t(ad(1, 'h24), v); chk("R6 clear ignored while data", v, 32'h10);
        rd_t(ad(1, 'h78), v); chk("R2 pop first", v, 32'h1111_0001);
        rd_t(ad(1, 'h78), v); chk("R2 pop second", v, 32'h1111_0002);
        rd_t(ad(1, 'h24), v); chk("R6 held after drain", v, 32'h10);
        wr_t(ad(1, 'h24), 32'h10);
        rd_t(ad(1, 'h24), v); chk("R6 clear when empty", v, 32'd0);

        // R8: enables and interrupt lines
        chk("R8 irq idle", 32'(irq), 32'd0);
        wr_t(ad(0, 'h30), 32'hFF);
        rd_t(ad(0, 'h30), v); chk("R8 wr enables odd only", v, 32'hAA);
        chk("R8 irq from write pending", 32'(irq), 32'd1);
        wr_t(ad(0, 'h30), 32'd0);
        rd_t(ad(0, 'h20), v);
        chk("R8 irq off after disable", 32'(irq), 32'd0);
        wr_t(ad(0, 'h20), 32'hFF);
        rd_t(ad(0, 'h20), v); chk("R8 rd enables even only", v, 32'h55);
        chk("R8 irq no read pending", 32'(irq), 32'd0);
        wr_t(ad(1, 'h20), 32'h10);
        wr_t(ad(1, 'h78), 32'h2222_0000);
        rd_t(ad(1, 'h60), v);
        chk("R8 irq from read pending", 32'(irq), 32'd2);
        rd_t(ad(1, 'h78), v); chk("R2 pop irq word", v, 32'h2222_0000);
        wr_t(ad(1, 'h24), 32'h10);
        rd_t(ad(1, 'h24), v);
        chk("R8 irq cleared", 32'(irq), 32'd0);
        wr_t(ad(0, 'h20), 32'd0);
        wr_t(ad(1, 'h20), 32'd0);

        // R9: push and pop in one cycle
        for (int k = 0; k < DEPTH; k++) wr_t(ad(0, 'h74), pat(0, 1, k));
        both_t(ad(0, 'h74), pat(0, 1, 50), v); chk("R9 full pop value", v, pat(0, 1, 0));
        rd_t(ad(0, 'h64), v); chk("R9 full count", v, 32'd8);
        rd_t(ad(0, 'h54), v); chk("R9 full no overflow", v, 32'd1);
        for (int k = 1; k < DEPTH; k++) begin
            rd_t(ad(0, 'h74), v); chk("R9 order after overlap", v, pat(0, 1, k));
        end
        rd_t(ad(0, 'h74), v); chk("R9 overlapped word last", v, pat(0, 1, 50));
        both_t(ad(0, 'h74), pat(0, 1, 60), v); chk("R9 empty pop value", v, 32'd0);
        rd_t(ad(0, 'h64), v); chk("R9 empty count", v, 32'd1);
        rd_t(ad(0, 'h74), v); chk("R9 stored word", v, pat(0, 1, 60));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule